// File: doc/BRIEF.md
# TPM Response Drain Sequencer

This block pulls a complete response out of a TPM-style interface after a command has run. It does this through a simple register-bus master port. It reads the status register to learn when data is waiting and how many bytes may be taken in a row. It then reads the data FIFO register one byte per access and passes every byte on over a valid/ready byte stream.

The caller pulses `start` and gives the size of its receive buffer. Until the response header has arrived, the sequencer uses that size as the transfer length. Once header bytes 2 to 5 are in, it takes them as a big-endian total length, checks it, and from then on reads exactly that many bytes. When the transfer ends, the status register must no longer report pending data. If it does not, the run fails. If it does, the sequencer writes the command-ready bit back to the status register and reports the byte count. Every status wait has a bounded number of polls, with a programmable pause between them.

Top module: `tpm_resp_drain`

## Requirements
- R1: After `start`, the block reads the status register until bit 7 (valid) and bit 4 (data available) are both 1. If POLL_LIMIT reads in a row fail this test, it finishes with result 1 (timeout) after exactly POLL_LIMIT status reads.
- R2: If the burst count in status bits 23:8 is 0, the block reads status again. After POLL_LIMIT re-reads that all show zero, it finishes with result 2 (stuck).
- R3: Each data byte costs exactly one read of the FIFO address. The block never reads more bytes than the last burst count allowed. A bus request stays up, with a stable address, until it is acknowledged.
- R4: Bytes 2, 3, 4 and 5 of the response, most significant first, give the total length. The block delivers exactly that many bytes.
- R5: If that length is less than 6 or greater than `buf_size`, the block finishes with result 3 (bad size) right after the sixth byte is delivered, and `byte_count` is 6.
- R6: Until the sixth byte has arrived, the transfer length equals `buf_size`.
- R7: After each burst, the block polls status for bit 7. It starts another burst only while bits 7 and 4 are both 1. If bit 7 is missing for POLL_LIMIT reads, it finishes with result 1.
- R8: If bit 4 is still 1 once the length is reached, the block finishes with result 4 (leftover) and does not write the status register.
- R9: On success, the block makes one write of 0x40 (bit 6, command ready) to the status address, then finishes with result 0 and `byte_count` equal to the number of bytes delivered.
- R10: While a byte is waiting on `out_valid` without `out_ready`, the byte stays stable and no FIFO read is issued. Such stalls do not consume poll budget.
- R11: After reset, `out_valid`, `done` and `bus_req` are 0.
- R12: `done` is high for exactly one cycle per run, and `result` and `byte_count` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a drain; ignored while busy |
| buf_size | input | LEN_W | Receive buffer capacity in bytes |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address (status or FIFO) |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data is valid in this cycle |
| bus_rdata | input | 32 | Read data |
| out_valid | output | 1 | Response byte available |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 stuck, 3 bad size, 4 leftover |
| byte_count | output | LEN_W | Bytes delivered in the run |

## Verification
A device model on the register bus serves responses with bursts of 1, 2, 3 and unlimited bytes. Comparing these shows whether the per-burst byte accounting and the re-poll between bursts are correct, rather than only the single-burst path. Some headers claim exactly 6 bytes, exactly the buffer size, fewer than 6, or more than the buffer, which separates the two size bounds from the normal length path. Other runs end early because the buffer is short, or the device holds extra bytes, stops reporting valid, never becomes ready, or keeps advertising a zero burst. These runs tell apart the leftover, timeout and stuck outcomes and their exact poll counts. A run with a stalling consumer confirms that stalls change neither the bytes nor their order.

// File: rtl/tpm_rd_pkg.sv
package tpm_rd_pkg;

  localparam int STS_VALID_BIT  = 7;
  localparam int STS_CMDRDY_BIT = 6;
  localparam int STS_AVAIL_BIT  = 4;
  localparam int BURST_LSB      = 8;
  localparam int BURST_W        = 16;
  localparam int HDR_BYTES      = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_DATA,
    ST_BURST_CHK,
    ST_BURST_POLL,
    ST_READ,
    ST_EMIT,
    ST_WAIT_VALID,
    ST_FINAL,
    ST_READY_WR
  } rd_state_e;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_TIMEOUT  = 3'd1,
    RC_STUCK    = 3'd2,
    RC_BAD_SIZE = 3'd3,
    RC_LEFTOVER = 3'd4
  } rd_code_e;

endpackage

// File: rtl/tpm_rd_bus_port.sv
module tpm_rd_bus_port #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [31:0]       go_wdata,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              busy,
  output logic              rsp
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (go && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= go_we;
      bus_addr  <= go_addr;
      bus_wdata <= go_wdata;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
    end
  end

  assign busy = bus_req;
  assign rsp  = bus_req && bus_ack;

endmodule

// File: rtl/tpm_rd_poll_timer.sv
module tpm_rd_poll_timer #(
  parameter int POLL_LIMIT = 1000000,
  parameter int POLL_GAP   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic fail,
  output logic hit_limit,
  output logic gap_idle
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 2);

  logic [CNT_W-1:0] fails_q;
  logic [GAP_W-1:0] gap_q;

  assign hit_limit = fail && (fails_q == CNT_W'(POLL_LIMIT - 1));
  assign gap_idle  = (gap_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fails_q <= '0;
    end else if (fail && !hit_limit) begin
      fails_q <= fails_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (fail) begin
      gap_q <= GAP_W'(POLL_GAP);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - GAP_W'(1);
    end
  end

endmodule

// File: rtl/tpm_rd_len_track.sv
module tpm_rd_len_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] buf_size,
  input  logic             take,
  input  logic [7:0]       byte_in,
  output logic [LEN_W-1:0] offset,
  output logic             at_end,
  output logic             size_bad
);

  import tpm_rd_pkg::*;

  logic [LEN_W-1:0] expect_q;
  logic [LEN_W-1:0] cap_q;
  logic [23:0]      hdr_q;
  logic [31:0]      hdr_len;
  logic             last_hdr;
  logic             in_len_field;

  assign hdr_len      = {hdr_q, byte_in};
  assign last_hdr     = (offset == LEN_W'(HDR_BYTES - 1));
  assign in_len_field = (offset >= LEN_W'(2)) && (offset < LEN_W'(HDR_BYTES - 1));
  assign size_bad     = take && last_hdr &&
                        ((hdr_len < 32'(HDR_BYTES)) || (hdr_len > 32'(cap_q)));
  assign at_end       = (offset == expect_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      offset   <= '0;
      expect_q <= '0;
      cap_q    <= '0;
      hdr_q    <= '0;
    end else if (load) begin
      offset   <= '0;
      expect_q <= buf_size;
      cap_q    <= buf_size;
      hdr_q    <= '0;
    end else if (take) begin
      offset <= offset + LEN_W'(1);
      if (in_len_field) begin
        hdr_q <= {hdr_q[15:0], byte_in};
      end
      if (last_hdr && !size_bad) begin
        expect_q <= hdr_len[LEN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tpm_resp_drain.sv
module tpm_resp_drain #(
  parameter int                LEN_W      = 16,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR   = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR  = 'h024,
  parameter int                POLL_LIMIT = 1000000,
  parameter int                POLL_GAP   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  buf_size,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              done,
  output logic [2:0]        result,
  output logic [LEN_W-1:0]  byte_count
);

  import tpm_rd_pkg::*;

  rd_state_e           state;
  logic [BURST_W-1:0]  burst_q;
  logic                avail_q;
  logic [BURST_W-1:0]  rd_burst;
  logic                rd_valid;
  logic                rd_avail;

  logic                go, go_we;
  logic [ADDR_W-1:0]   go_addr;
  logic [31:0]         go_wdata;
  logic                busy, rsp;
  logic                tmr_clr, tmr_fail, hit_limit, gap_idle;
  logic                take, size_bad, at_end;
  logic [LEN_W-1:0]    offset;
  logic                polling, poll_ok;
  logic                fin;
  rd_code_e            fin_code;
  logic [LEN_W-1:0]    fin_count;
  logic                unused_rdata;

  assign rd_burst     = bus_rdata[BURST_LSB +: BURST_W];
  assign rd_valid     = bus_rdata[STS_VALID_BIT];
  assign rd_avail     = bus_rdata[STS_AVAIL_BIT];
  assign unused_rdata = ^{bus_rdata[31:24], bus_rdata[6:5], bus_rdata[3:0]};

  tpm_rd_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_wdata(go_wdata), .bus_ack(bus_ack), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .rsp(rsp)
  );

  tpm_rd_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .fail(tmr_fail),
    .hit_limit(hit_limit), .gap_idle(gap_idle)
  );

  tpm_rd_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .load(state == ST_IDLE && start),
    .buf_size(buf_size), .take(take), .byte_in(out_data),
    .offset(offset), .at_end(at_end), .size_bad(size_bad)
  );

  // Bus launches, poll evaluation and run termination
  always_comb begin
    go       = 1'b0;
    go_we    = 1'b0;
    go_addr  = STS_ADDR;
    go_wdata = '0;
    polling  = (state == ST_WAIT_DATA) || (state == ST_BURST_POLL) ||
               (state == ST_WAIT_VALID);
    case (state)
      ST_WAIT_DATA:  poll_ok = rd_valid && rd_avail;
      ST_BURST_POLL: poll_ok = (rd_burst != '0);
      default:       poll_ok = rd_valid;
    endcase
    if (polling && !busy && gap_idle) go = 1'b1;
    if (state == ST_READ && !busy && burst_q != '0 && !at_end) begin
      go      = 1'b1;
      go_addr = FIFO_ADDR;
    end
    if (state == ST_FINAL && !avail_q && !busy) begin
      go       = 1'b1;
      go_we    = 1'b1;
      go_wdata = 32'(1) << STS_CMDRDY_BIT;
    end
    take     = (state == ST_EMIT) && out_ready;
    tmr_fail = polling && rsp && !poll_ok;
    tmr_clr  = (state == ST_IDLE && start) || (polling && rsp && poll_ok);

    fin       = 1'b0;
    fin_code  = RC_OK;
    fin_count = offset;
    if (tmr_fail && hit_limit) begin
      fin      = 1'b1;
      fin_code = (state == ST_BURST_POLL) ? RC_STUCK : RC_TIMEOUT;
    end
    if (take && size_bad) begin
      fin       = 1'b1;
      fin_code  = RC_BAD_SIZE;
      fin_count = offset + LEN_W'(1);
    end
    if (state == ST_FINAL && avail_q) begin
      fin      = 1'b1;
      fin_code = RC_LEFTOVER;
    end
    if (state == ST_READY_WR && rsp) begin
      fin = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      burst_q   <= '0;
      avail_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fin) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_WAIT_DATA;
        ST_WAIT_DATA: if (rsp && poll_ok) begin
          avail_q <= rd_avail;
          burst_q <= rd_burst;
          state   <= ST_BURST_CHK;
        end
        ST_BURST_CHK: state <= (burst_q != '0) ? ST_READ : ST_BURST_POLL;
        ST_BURST_POLL: if (rsp && poll_ok) begin
          burst_q <= rd_burst;
          state   <= ST_READ;
        end
        ST_READ: begin
          if (rsp) begin
            out_data  <= bus_rdata[7:0];
            out_valid <= 1'b1;
            state     <= ST_EMIT;
          end else if (!busy && (burst_q == '0 || at_end)) begin
            state <= ST_WAIT_VALID;
          end
        end
        ST_EMIT: if (out_ready) begin
          out_valid <= 1'b0;
          burst_q   <= burst_q - BURST_W'(1);
          state     <= ST_READ;
        end
        ST_WAIT_VALID: if (rsp && poll_ok) begin
          avail_q <= rd_avail;
          if (!at_end && rd_avail) begin
            burst_q <= rd_burst;
            state   <= ST_BURST_CHK;
          end else begin
            state <= ST_FINAL;
          end
        end
        ST_FINAL: state <= ST_READY_WR;
        ST_READY_WR: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      result     <= RC_OK;
      byte_count <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        result     <= fin_code;
        byte_count <= fin_count;
      end
    end
  end

endmodule

// File: rtl/tpm_rd_chk.sv
module tpm_rd_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h024
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ready,
  input logic              done
);

  assert_byte_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_no_fifo_read_while_pending_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(bus_req && !bus_we && bus_addr == FIFO_ADDR));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  assert_ready_write_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> bus_addr == STS_ADDR && bus_wdata == 32'h40);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind tpm_resp_drain tpm_rd_chk #(
  .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .FIFO_ADDR(FIFO_ADDR)
) u_rd_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .done(done)
);

// File: tb/test_tpm_resp_drain.sv
module test_tpm_resp_drain;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int ADDR_W     = 12;
  localparam logic [ADDR_W-1:0] STS_A  = 12'h018;
  localparam logic [ADDR_W-1:0] FIFO_A = 12'h024;
  localparam int LIMIT      = 6;
  localparam int GAP        = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] buf_size = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic out_valid, out_ready = 1'b1, done;
  logic [7:0] out_data;
  logic [2:0] result;
  logic [LEN_W-1:0] byte_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_resp_drain #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .STS_ADDR(STS_A), .FIFO_ADDR(FIFO_A),
    .POLL_LIMIT(LIMIT), .POLL_GAP(GAP)
  ) i_tpm_resp_drain (
    .clk(clk), .rst(rst), .start(start), .buf_size(buf_size),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .result(result), .byte_count(byte_count)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Device model state
  logic [7:0] dev_q[$];
  logic [7:0] exp_q[$];
  int burst_knob = 64;
  int not_ready_polls = 0;
  int zero_burst_polls = 0;
  bit stuck = 0;
  int valid_drop_at = -1;
  int popped = 0;
  int sts_reads = 0;
  int burst_left = 0;
  int over_burst = 0;
  int wr_count = 0;
  logic [31:0] last_wr = '0;
  bit bp_mode = 0;
  int cyc = 0;

  // Register-bus device model
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        bus_ack = 1'b1;
        if (bus_we) begin
          wr_count++;
          last_wr = bus_wdata;
        end else if (bus_addr == STS_A) begin
          sts_reads++;
          if (not_ready_polls > 0) begin
            not_ready_polls--;
            bus_rdata = 32'h0;
          end else begin
            bit v, a;
            int b;
            v = !(valid_drop_at >= 0 && popped >= valid_drop_at);
            a = dev_q.size() > 0;
            if (stuck) b = 0;
            else if (zero_burst_polls > 0 && a) begin
              zero_burst_polls--;
              b = 0;
            end else b = (dev_q.size() < burst_knob) ? dev_q.size() : burst_knob;
            burst_left = b;
            bus_rdata = {8'h00, 16'(b), v, 2'b00, a, 4'h0};
          end
        end else begin
          if (burst_left == 0) over_burst++;
          else burst_left--;
          if (dev_q.size() > 0) begin
            bus_rdata = {24'h0, dev_q.pop_front()};
            popped++;
          end else bus_rdata = 32'h0;
        end
      end
    end
  end

  // Scoreboard monitor and consumer
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected byte", out_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R4 byte value", out_data, e);
        end
      end
    end
  end

  task automatic run_case(input string tag, input int total, input int claimed,
                          input int bufsz, input int n_out, input int code,
                          input int cnt, input int wr_exp);
    logic [7:0] b;
    int waited;
    dev_q.delete();
    exp_q.delete();
    popped = 0; sts_reads = 0; over_burst = 0; wr_count = 0; burst_left = 0;
    for (int i = 0; i < total; i++) begin
      case (i)
        0: b = 8'h00;
        1: b = 8'hC4;
        2: b = claimed[31:24];
        3: b = claimed[23:16];
        4: b = claimed[15:8];
        5: b = claimed[7:0];
        default: b = 8'(i * 7 + 3);
      endcase
      dev_q.push_back(b);
      if (i < n_out) exp_q.push_back(b);
    end
    @(negedge clk);
    start = 1'b1;
    buf_size = LEN_W'(bufsz);
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (done !== 1'b1 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(done === 1'b1, {tag, " R12 done seen"}, done, 1);
    chk(result == 3'(code), {tag, " result"}, result, code);
    chk(byte_count == LEN_W'(cnt), {tag, " byte_count"}, byte_count, cnt);
    chk(exp_q.size() == 0, {tag, " R4 all bytes delivered"}, exp_q.size(), 0);
    chk(wr_count == wr_exp, {tag, " R9/R8 status writes"}, wr_count, wr_exp);
    if (wr_exp > 0) chk(last_wr == 32'h40, {tag, " R9 write value"}, last_wr, 32'h40);
    chk(over_burst == 0, {tag, " R3 reads within burst"}, over_burst, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R12 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid at reset", out_valid, 0);
    chk(done == 1'b0, "R11 done at reset", done, 0);
    chk(bus_req == 1'b0, "R11 bus_req at reset", bus_req, 0);
    rst = 1'b0;

    burst_knob = 64;
    run_case("R4 R9 single burst", 10, 10, 32, 10, 0, 10, 1);

    burst_knob = 3; bp_mode = 1;
    run_case("R3 R10 bursts of 3 with stalls", 20, 20, 32, 20, 0, 20, 1);
    bp_mode = 0;

    burst_knob = 1; not_ready_polls = 3; zero_burst_polls = 2;
    run_case("R1 R2 late ready, zero bursts", 12, 12, 32, 12, 0, 12, 1);
    burst_knob = 64;

    run_case("R5 length above buffer", 40, 40, 32, 6, 3, 6, 0);
    run_case("R5 length below six", 10, 4, 32, 6, 3, 6, 0);
    run_case("R4 length exactly six", 6, 6, 32, 6, 0, 6, 1);
    run_case("R5 length equals buffer", 16, 16, 16, 16, 0, 16, 1);
    run_case("R6 short buffer exact", 4, 0, 4, 4, 0, 4, 1);
    run_case("R6 R8 short buffer leftover", 10, 10, 4, 4, 4, 4, 0);
    run_case("R8 extra device bytes", 11, 8, 32, 8, 4, 8, 0);

    not_ready_polls = 1000;
    run_case("R1 never ready", 8, 8, 32, 0, 1, 0, 0);
    chk(sts_reads == LIMIT, "R1 timeout poll count", sts_reads, LIMIT);
    not_ready_polls = 0;

    stuck = 1;
    run_case("R2 stuck burst", 8, 8, 32, 0, 2, 0, 0);
    chk(sts_reads == LIMIT + 1, "R2 stuck poll count", sts_reads, LIMIT + 1);
    stuck = 0;

    burst_knob = 2; valid_drop_at = 3;
    run_case("R7 valid lost between bursts", 12, 12, 32, 4, 1, 4, 0);
    valid_drop_at = -1; burst_knob = 64;

    run_case("R9 recovery run", 9, 9, 32, 9, 0, 9, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule